// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers eight interrupt sources for a small 16-bit core and presents a single request line plus the 3-bit index of the winning source. Each source has a pending flag. A rising edge on the source pin sets it, and a write from the register bus can also set or clear it. A mask input suppresses the source and wipes its flag. Priority is fixed: source 0 is the most urgent and source 7 the least.

The controller tracks the priority level the core is running at. When the core finishes an acknowledge handshake, the serviced source's flag drops. The running level is saved on a three-entry stack and the serviced source's index becomes the new running level. A one-cycle return pulse restores the saved level. A request reaches the core only when the winning source outranks the running level, so interrupts nest up to three deep. Software may overwrite the stack depth, which reloads the running level from the stack.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x0000 and `irq_o` is low. The running level is idle, which is encoded as 8 and is below every source.
- R2: A 0-to-1 change on `irq_i[k]`, seen at a clock edge while `mask_i[k]` is 0, sets pending bit k at that edge. A pin held high does not set the bit again after it has been cleared.
- R3: The acknowledge handshake takes effect when `ack_i` falls. At that point the pending bit of the source that `vec_o` named when `ack_i` rose is cleared.
- R4: While `mask_i[k]` is 1, pending bit k is forced to 0 at each edge. The source is also ignored when `irq_o` and `vec_o` are formed.
- R5: The depth register holds 0 to 3 and resets to 0. A written value above 3 is stored as 3.
- R6: On the acknowledge fall, the running level is pushed and the depth increments, saturating at 3. The serviced index becomes the running level. A `reti_i` pulse pops the saved level and decrements the depth. When the depth is already 0, the pulse leaves it at 0 and sets the running level to idle.
- R7: Writing the status register loads the pending bits from bits 7..0 of the write data. A 1 raises a request whatever the pin level. Writing 0 drops every pending request.
- R8: If a pin rising edge and a software write of 0 hit the same pending bit in the same cycle, the bit ends up set.
- R9: `vec_o` gives the lowest-indexed unmasked pending source. `irq_o` is high exactly when such a source exists and its index is below the running level.
- R10: Writing depth value v sets the running level to stack entry v-1, or to idle when v is 0.
- R11: Register map: address 0 is status, with pending bits in 7..0. Address 1 is depth, in bits 2..0. All other bits and addresses read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Synchronous interrupt request pins |
| mask_i | input | 8 | Per-source mask, 1 = masked |
| ack_i | input | 1 | Acknowledge from core; completes on falling edge |
| reti_i | input | 1 | One-cycle return-from-interrupt pulse |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 3 | Index of the highest-priority unmasked pending source |

## Verification
The assertions assume that `irq_i`, `mask_i`, `ack_i` and `reti_i` are synchronous to `clk_i`. They also assume that `ack_i` and `reti_i` do not change state in the same cycle as a depth write, because that write takes precedence over push and pop. The stimulus changes every input only on the falling clock edge. Acknowledges are driven as a one-cycle high followed by a low cycle, and return pulses last exactly one cycle. Depth writes are always issued while `ack_i` and `reti_i` are idle.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_SP   = 2'd1;
endpackage

// File: rtl/nest_irq_pend.sv
module nest_irq_pend #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             sw_wr_i,
  input  logic [N_SRC-1:0] sw_data_i,
  input  logic             ack_clr_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] irq_q;
  logic [N_SRC-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_bit
    logic rise, nxt;
    assign rise = irq_i[k] & ~irq_q[k];

    always_comb begin
      nxt = pend_q[k];
      if (sw_wr_i) nxt = sw_data_i[k];
      if (ack_clr_i && (ack_idx_i == IDX_W'(k))) nxt = 1'b0;
      if (rise) nxt = 1'b1;                 // hardware set wins
      if (mask_i[k]) nxt = 1'b0;            // mask overrides all
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[k] <= 1'b0;
      else         pend_q[k] <= nxt;
    end

    AST_MASK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_i[k] |=> !pend_q[k]); // R4
    AST_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_i[k] && !irq_q[k] && !mask_i[k]) |=> pend_q[k]); // R8
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/nest_irq_prio.sv
module nest_irq_prio #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned LVL_W = IDX_W + 1
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] vec_o
);
  logic [N_SRC-1:0] elig;
  logic             found;
  logic [IDX_W-1:0] idx;

  assign elig = pend_i & ~mask_i;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (elig[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end

  assign vec_o = idx;
  assign irq_o = found && ({1'b0, idx} < cur_lvl_i);
endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned SP_W  = 3,
  parameter int unsigned LVL_W = 4,
  localparam int unsigned SI_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam logic [LVL_W-1:0] IDLE = {1'b1, {(LVL_W-1){1'b0}}}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  input  logic             sp_wr_i,
  input  logic [SP_W-1:0]  sp_wdata_i,
  output logic [SP_W-1:0]  sp_o,
  output logic [LVL_W-1:0] cur_lvl_o
);
  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [SP_W-1:0]  sp_q;
  logic [LVL_W-1:0] cur_q;
  logic [SP_W-1:0]  wv;

  assign wv = (sp_wdata_i > SP_W'(DEPTH)) ? SP_W'(DEPTH) : sp_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      cur_q <= IDLE;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= IDLE;
    end else if (sp_wr_i) begin
      sp_q  <= wv;
      cur_q <= (wv == '0) ? IDLE : stk_q[SI_W'(wv - 1'b1)];
    end else if (push_i) begin
      if (sp_q < SP_W'(DEPTH)) begin
        stk_q[SI_W'(sp_q)] <= cur_q;
        sp_q <= sp_q + 1'b1;
      end
      cur_q <= push_lvl_i;
    end else if (pop_i) begin
      if (sp_q != '0) begin
        cur_q <= stk_q[SI_W'(sp_q - 1'b1)];
        sp_q  <= sp_q - 1'b1;
      end else begin
        cur_q <= IDLE;
      end
    end
  end

  assign sp_o      = sp_q;
  assign cur_lvl_o = cur_q;

  AST_SP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SP_W'(DEPTH)); // R5
  AST_PUSH_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !sp_wr_i && sp_q < SP_W'(DEPTH)) |=> sp_q == $past(sp_q) + 1'b1); // R6
  AST_POP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !sp_wr_i && sp_q != '0) |=> sp_q == $past(sp_q) - 1'b1); // R6
  AST_SPWR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_wr_i && sp_wdata_i == '0) |=> cur_q == IDLE); // R10
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nest_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned DEPTH  = 3,
  parameter int unsigned SP_W   = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned LVL_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic [N_SRC-1:0]  mask_i,
  input  logic              ack_i,
  input  logic              reti_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  vec_o
);
  logic             ack_q;
  logic [IDX_W-1:0] ack_src_q;
  logic             ack_rise, ack_fall;
  logic             st_wr, sp_wr;
  logic [N_SRC-1:0] pend;
  logic [SP_W-1:0]  sp;
  logic [LVL_W-1:0] cur_lvl;
  logic             unused_wdata;

  assign ack_rise = ack_i & ~ack_q;
  assign ack_fall = ~ack_i & ack_q;
  assign st_wr    = wr_i && (addr_i == ADDR_W'(ADDR_STAT));
  assign sp_wr    = wr_i && (addr_i == ADDR_W'(ADDR_SP));
  assign unused_wdata = ^wdata_i[DATA_W-1:N_SRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q     <= 1'b0;
      ack_src_q <= '0;
    end else begin
      ack_q <= ack_i;
      if (ack_rise) ack_src_q <= vec_o;
    end
  end

  nest_irq_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .mask_i    (mask_i),
    .sw_wr_i   (st_wr),
    .sw_data_i (wdata_i[N_SRC-1:0]),
    .ack_clr_i (ack_fall),
    .ack_idx_i (ack_src_q),
    .pend_o    (pend)
  );

  nest_irq_stack #(.DEPTH(DEPTH), .SP_W(SP_W), .LVL_W(LVL_W)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (ack_fall),
    .push_lvl_i ({1'b0, ack_src_q}),
    .pop_i      (reti_i),
    .sp_wr_i    (sp_wr),
    .sp_wdata_i (wdata_i[SP_W-1:0]),
    .sp_o       (sp),
    .cur_lvl_o  (cur_lvl)
  );

  nest_irq_prio #(.N_SRC(N_SRC)) u_prio (
    .pend_i    (pend),
    .mask_i    (mask_i),
    .cur_lvl_i (cur_lvl),
    .irq_o     (irq_o),
    .vec_o     (vec_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_STAT))    rdata_o[N_SRC-1:0] = pend;
    else if (addr_i == ADDR_W'(ADDR_SP)) rdata_o[SP_W-1:0]  = sp;
  end

  AST_IRQ_HAS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(pend & ~mask_i)); // R9
  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fall && !st_wr && !(irq_i[ack_src_q] && !$past(irq_i[ack_src_q])))
      |=> !pend[$past(ack_src_q)]); // R3
endmodule

// File: tb/nest_irq_ctrl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq = '0, mask = '0;
  logic        ack = 1'b0, reti = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_o;
  logic [2:0]  vec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nest_irq_ctrl u_nest_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mask_i(mask), .ack_i(ack),
    .reti_i(reti), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq_o), .vec_o(vec)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk);
    ack = 1'b0; @(negedge clk);
  endtask

  task automatic do_reti();
    reti = 1'b1; @(negedge clk);
    reti = 1'b0;
  endtask

  function automatic int low_idx(input logic [7:0] p);
    for (int k = 7; k >= 0; k--) if (p[k]) low_idx = k;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0] masks [6];
    masks = '{8'h00, 8'h01, 8'h80, 8'h55, 8'hAA, 8'hFF};
    repeat (3) @(negedge clk);
    rd(2'd0, d); chk("R1 status", d, 0);
    rd(2'd1, d); chk("R1 depth", d, 0);
    chk("R1 irq", irq_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep pending patterns under several masks, idle level
    foreach (masks[m]) begin
      mask = masks[m];
      for (int p = 0; p < 256; p++) begin
        logic [7:0] e;
        e = 8'(p) & ~mask;
        wreg(2'd0, 16'(p));
        rd(2'd0, d); chk("R7/R4 status", d, e);
        chk("R9 irq", irq_o, (e != 0));
        if (e != 0) chk("R9 vec", vec, low_idx(e));
      end
    end
    mask = '0;
    wreg(2'd0, 16'h0000);
    rd(2'd0, d); chk("R7 clear all", d, 0);

    // nesting
    wreg(2'd0, 16'h0020);
    chk("R9 irq src5", irq_o, 1); chk("R9 vec src5", vec, 5);
    do_ack();
    rd(2'd0, d); chk("R3 bit5 cleared", d, 0);
    rd(2'd1, d); chk("R6 depth after ack", d, 1);
    wreg(2'd0, 16'h0080);
    chk("R9 lower src blocked", irq_o, 0);
    wreg(2'd0, 16'h0084);
    chk("R9 higher src irq", irq_o, 1); chk("R9 higher src vec", vec, 2);
    do_ack();
    rd(2'd0, d); chk("R3 bit2 cleared", d, 16'h0080);
    rd(2'd1, d); chk("R6 depth 2", d, 2);
    chk("R9 irq at level2", irq_o, 0);
    do_reti();
    rd(2'd1, d); chk("R6 pop depth1", d, 1);
    chk("R6 level5 restored", irq_o, 0);
    do_reti();
    rd(2'd1, d); chk("R6 pop depth0", d, 0);
    chk("R6 idle irq", irq_o, 1); chk("R6 idle vec", vec, 7);
    wreg(2'd0, 16'h0000);

    // saturation
    for (int i = 0; i < 4; i++) begin
      wreg(2'd0, 16'h0001);
      do_ack();
    end
    rd(2'd1, d); chk("R6 depth saturates 3", d, 3);
    for (int i = 0; i < 4; i++) do_reti();
    rd(2'd1, d); chk("R6 depth floor 0", d, 0);
    wreg(2'd0, 16'h0080);
    chk("R6 idle after extra reti", irq_o, 1);
    wreg(2'd0, 16'h0000);

    // depth rewrite
    wreg(2'd0, 16'h0008); do_ack();
    wreg(2'd0, 16'h0002); do_ack();
    wreg(2'd0, 16'h0004);
    chk("R10 blocked at level1", irq_o, 0);
    wreg(2'd1, 16'd1);
    chk("R10 depth1 -> idle", irq_o, 1); chk("R10 vec", vec, 2);
    wreg(2'd1, 16'd2);
    chk("R10 depth2 -> level3", irq_o, 1);
    wreg(2'd1, 16'd0);
    rd(2'd1, d); chk("R10 depth0", d, 0);
    chk("R10 depth0 -> idle", irq_o, 1);
    wreg(2'd1, 16'd7);
    rd(2'd1, d); chk("R5 clip to 3", d, 3);
    chk("R10 depth3 -> level0", irq_o, 0);
    wreg(2'd1, 16'hFFF8);
    rd(2'd1, d); chk("R11 depth upper bits", d, 0);
    wreg(2'd0, 16'h0000);

    // hardware set beats software clear
    irq[4] = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 16'h0000;
    @(negedge clk);
    wr = 1'b0; irq[4] = 1'b0;
    rd(2'd0, d); chk("R8 hw wins", d, 16'h0010);
    wreg(2'd0, 16'h0000);

    // rising edge only
    irq[6] = 1'b1; @(negedge clk);
    rd(2'd0, d); chk("R2 edge sets", d, 16'h0040);
    wreg(2'd0, 16'h0000);
    repeat (2) @(negedge clk);
    rd(2'd0, d); chk("R2 level no reset", d, 0);
    irq[6] = 1'b0; @(negedge clk);

    // masking wipes pending
    wreg(2'd0, 16'h0008);
    mask = 8'h08; @(negedge clk);
    rd(2'd0, d); chk("R4 mask clears", d, 0);
    chk("R4 irq masked", irq_o, 0);
    mask = '0; @(negedge clk);
    rd(2'd0, d); chk("R4 stays cleared", d, 0);

    // register map
    wreg(2'd0, 16'hFFFF);
    rd(2'd0, d); chk("R11 status upper", d, 16'h00FF);
    rd(2'd2, d); chk("R11 addr2", d, 0);
    rd(2'd3, d); chk("R11 addr3", d, 0);
    wreg(2'd3, 16'h0000);
    rd(2'd0, d); chk("R11 addr3 write ignored", d, 16'h00FF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule